// File: doc/BRIEF.md
# DVFS Transition Sequencer

This block steps a processor between operating points when its frequency is scaled at run time. Software requests a new operating point by pulsing a write strobe together with a 3-bit frequency index. The block compares the request with the index now in force. Each index has a fixed supply code, held in a parameter table. The block then drives a regulator voltage-select output and a clock-select output, one at a time, in an order that keeps the clock within what the supply can carry.

When the index rises, the supply code moves first. The clock follows only after a voltage settling interval. When the index falls, the clock slows first and the supply drops only after a clock settling interval. Both intervals are cycle-count parameters, sized for waits of tens of microseconds. A busy flag covers the whole change and a one-cycle completion pulse marks its end.

Requests that arrive during a change are not lost. The most recent one is parked and started as soon as the running change completes. A request for the index already in force completes at once without a sequence.

Top module: `dvfs_seq`

## Requirements
- R1: After synchronous active-low reset, `clk_sel` equals parameter RESET_IDX, `volt_sel` equals that index's table code, and `busy` and `done` are 0.
- R2: A write (`req_valid` high for one cycle with `req_idx`) of an index different from `clk_sel`, made while idle, raises `busy` in the following cycle. `busy` then stays high without a break until the change completes.
- R3: The supply code for index i is bits [4*i+3 : 4*i] of VOLT_TABLE. At the end of every change, `volt_sel` equals the code of the new `clk_sel`.
- R4: On a rising change, `volt_sel` takes the new code in the cycle after `busy` rises. `clk_sel` changes V_SETTLE+1 cycles later.
- R5: On a falling change, `clk_sel` takes the new index in the cycle after `busy` rises. `volt_sel` changes F_SETTLE+1 cycles later.
- R6: `done` is high for exactly one cycle. It rises F_SETTLE cycles after the second output change on a rising change, or V_SETTLE cycles after it on a falling change. `busy` is low in the cycle after `done`.
- R7: A write of the index already in `clk_sel`, made while idle, gives `done` high in the next cycle, leaves `busy` low and changes neither output.
- R8: Writes made while a change is running are parked. Only the latest one is kept, and it starts in the cycle after `done` without `busy` dropping.
- R9: A write in the `done` cycle takes precedence over any parked request.
- R10: A parked request equal to the index just reached is dropped. It produces no further `busy` and no further `done`.
- R11: `volt_sel` and `clk_sel` never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle write strobe for a new frequency index |
| req_idx | input | 3 | Requested frequency index |
| volt_sel | output | 4 | Supply code to the regulator |
| clk_sel | output | 3 | Frequency index to the clock generator |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The block is driven with single rising and falling requests whose output changes are timed cycle by cycle. This separates the two step orders and shows whether each settling wait is applied to the correct step. Writes of the current index show whether the short path is taken. Bursts of writes during a change, a write placed in the completion cycle, and a parked copy of the index just reached show which request wins and whether stale ones are dropped. A sweep that includes both end indices checks the table lookup, while a behavioural model is compared against all four outputs on every clock.

// File: rtl/dvfs_seq_pkg.sv
// Shared types for the DVFS transition sequencer.
// Assumes nothing beyond the sequencer's own state set.
package dvfs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RAISE_V = 3'd1,
        ST_WAIT_V  = 3'd2,
        ST_SET_F   = 3'd3,
        ST_WAIT_F  = 3'd4,
        ST_LOWER_V = 3'd5,
        ST_DONE    = 3'd6
    } seq_state_t;

endpackage

// File: rtl/dvfs_volt_lut.sv
// Frequency-index to supply-code lookup.
// The table is a packed parameter, with entry i in slice i.
// Assumes NUM_LVL covers every value of the index.
module dvfs_volt_lut #(
    parameter int IDX_W   = 3,
    parameter int VCODE_W = 4,
    parameter int NUM_LVL = 1 << IDX_W,
    parameter logic [NUM_LVL*VCODE_W-1:0] TABLE = '0
) (
    input  logic [IDX_W-1:0]   idx,
    output logic [VCODE_W-1:0] code
);

    logic [VCODE_W-1:0] entry [NUM_LVL];

    // unpack one table slice per level
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_entry
        assign entry[g] = TABLE[g*VCODE_W +: VCODE_W];
    end

    assign code = entry[idx];

endmodule

// File: rtl/dvfs_settle_timer.sv
// Down-counter for the settling waits.
// A load sets the count. The count then runs down to zero and holds there.
// Assumes the caller loads (wait length - 1).
module dvfs_settle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // load or count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dvfs_req_hold.sv
// One-deep holding register for requests that arrive during a change.
// A newer capture overwrites an older one. Consume clears the register and takes precedence.
module dvfs_req_hold #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             consume,
    output logic             pend_vld,
    output logic [IDX_W-1:0] pend_idx
);

    // keep only the most recent parked index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_idx <= '0;
        end else if (consume) begin
            pend_vld <= 1'b0;
        end else if (capture) begin
            pend_vld <= 1'b1;
            pend_idx <= cap_idx;
        end
    end

endmodule

// File: rtl/dvfs_seq.sv
// DVFS transition sequencer top.
// Orders supply and clock changes by direction and waits out each settling time.
// Assumes V_SETTLE >= 1, F_SETTLE >= 1 and a table entry for every index.
module dvfs_seq
    import dvfs_seq_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int VCODE_W   = 4,
    parameter int V_SETTLE  = 2500,
    parameter int F_SETTLE  = 1250,
    parameter int RESET_IDX = 0,
    parameter logic [(1<<IDX_W)*VCODE_W-1:0] VOLT_TABLE = 32'hFDBA8765
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_idx,
    output logic [VCODE_W-1:0] volt_sel,
    output logic [IDX_W-1:0]   clk_sel,
    output logic               busy,
    output logic               done
);

    localparam int NUM_LVL    = 1 << IDX_W;
    localparam int MAX_SETTLE = (V_SETTLE > F_SETTLE) ? V_SETTLE : F_SETTLE;
    localparam int CNT_W      = $clog2(MAX_SETTLE + 1);
    localparam logic [VCODE_W-1:0] RST_CODE = VOLT_TABLE[RESET_IDX*VCODE_W +: VCODE_W];
    localparam logic [IDX_W-1:0]   RST_IDX  = IDX_W'(RESET_IDX);

    seq_state_t         state_q;
    logic [IDX_W-1:0]   tgt_q;
    logic               up_q;
    logic [IDX_W-1:0]   fsel_q;
    logic [VCODE_W-1:0] vsel_q;
    logic               triv_q;

    logic               pend_vld;
    logic [IDX_W-1:0]   pend_idx;
    logic [VCODE_W-1:0] tgt_code;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_exp;

    logic               at_rest;
    logic               cand_vld;
    logic [IDX_W-1:0]   cand_idx;
    logic               start;

    dvfs_volt_lut #(
        .IDX_W(IDX_W), .VCODE_W(VCODE_W), .NUM_LVL(NUM_LVL), .TABLE(VOLT_TABLE)
    ) u_lut (
        .idx(tgt_q), .code(tgt_code)
    );

    dvfs_settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    dvfs_req_hold #(.IDX_W(IDX_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .capture(req_valid && !at_rest), .cap_idx(req_idx),
        .consume(state_q == ST_DONE),
        .pend_vld(pend_vld), .pend_idx(pend_idx)
    );

    // choose the request to act on: a new write wins over a parked one
    always_comb begin
        at_rest  = (state_q == ST_IDLE) || (state_q == ST_DONE);
        cand_vld = req_valid || ((state_q == ST_DONE) && pend_vld);
        cand_idx = req_valid ? req_idx : pend_idx;
        start    = at_rest && cand_vld && (cand_idx != fsel_q);
    end

    // settling timer load points and lengths
    always_comb begin
        tmr_load = (state_q == ST_RAISE_V) || (state_q == ST_LOWER_V) || (state_q == ST_SET_F);
        tmr_val  = (state_q == ST_SET_F) ? CNT_W'(F_SETTLE - 1) : CNT_W'(V_SETTLE - 1);
    end

    // sequence state, target and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= RST_IDX;
            up_q    <= 1'b0;
            fsel_q  <= RST_IDX;
            vsel_q  <= RST_CODE;
            triv_q  <= 1'b0;
        end else begin
            triv_q <= (state_q == ST_IDLE) && req_valid && (req_idx == fsel_q);
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        tgt_q   <= cand_idx;
                        up_q    <= (cand_idx > fsel_q);
                        state_q <= (cand_idx > fsel_q) ? ST_RAISE_V : ST_SET_F;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_RAISE_V, ST_LOWER_V: begin
                    vsel_q  <= tgt_code;
                    state_q <= ST_WAIT_V;
                end
                ST_WAIT_V: begin
                    if (tmr_exp) state_q <= up_q ? ST_SET_F : ST_DONE;
                end
                ST_SET_F: begin
                    fsel_q  <= tgt_q;
                    state_q <= ST_WAIT_F;
                end
                ST_WAIT_F: begin
                    if (tmr_exp) state_q <= up_q ? ST_DONE : ST_LOWER_V;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign volt_sel = vsel_q;
    assign clk_sel  = fsel_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE) || triv_q;

endmodule

// File: rtl/dvfs_seq_chk.sv
// Port-level protocol checks for dvfs_seq, attached with bind.
module dvfs_seq_chk #(
    parameter int IDX_W   = 3,
    parameter int VCODE_W = 4,
    parameter logic [(1<<IDX_W)*VCODE_W-1:0] VOLT_TABLE = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_idx,
    input logic [VCODE_W-1:0] volt_sel,
    input logic [IDX_W-1:0]   clk_sel,
    input logic               busy,
    input logic               done
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(volt_sel) && !$stable(clk_sel)));

    // R7
    same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_idx == clk_sel) |=> (done && !busy));

    // R4
    up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel > $past(clk_sel)) |-> (volt_sel == VOLT_TABLE[clk_sel*VCODE_W +: VCODE_W]));

    // R5
    down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel < $past(clk_sel)) |-> $stable(volt_sel));

    // R3
    paired_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (volt_sel == VOLT_TABLE[clk_sel*VCODE_W +: VCODE_W]));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind dvfs_seq dvfs_seq_chk #(
    .IDX_W(IDX_W), .VCODE_W(VCODE_W), .VOLT_TABLE(VOLT_TABLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .volt_sel(volt_sel), .clk_sel(clk_sel), .busy(busy), .done(done)
);

// File: tb/dvfs_seq_test.sv
// Bench for dvfs_seq: directed checks plus a per-clock behavioural model.
module dvfs_seq_test;

    localparam int VS = 12;
    localparam int FS = 7;

    function automatic logic [3:0] tbl(input int i);
        return 4'((i * 3 + 2) % 16);
    endfunction

    function automatic logic [31:0] build_tbl();
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) r[i*4 +: 4] = tbl(i);
        return r;
    endfunction

    localparam logic [31:0] TB_TABLE = build_tbl();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_idx = '0;
    logic [3:0] volt_sel;
    logic [2:0] clk_sel;
    logic       busy;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] seen;
    int done_cnt;

    always #4 clk = ~clk;

    dvfs_seq #(
        .IDX_W(3), .VCODE_W(4), .V_SETTLE(VS), .F_SETTLE(FS),
        .RESET_IDX(0), .VOLT_TABLE(TB_TABLE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .volt_sel(volt_sel), .clk_sel(clk_sel), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int cyc, t1, t2, td, m_triv;
    int m_v, m_f, m_tgt, m_pend;
    bit m_busy, m_up, m_pv;
    int e_v, e_f; bit e_busy, e_done;

    task automatic m_start(input int c, input int x);
        m_busy = 1; m_tgt = x; m_up = (x > m_f);
        t1 = c + 1;
        t2 = c + 2 + (m_up ? VS : FS);
        td = t2 + (m_up ? FS : VS);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; t1 = -10; t2 = -10; td = -10; m_triv = -10;
            m_v = tbl(0); m_f = 0; m_busy = 0; m_pv = 0; m_pend = 0; m_up = 0; m_tgt = 0;
        end else begin
            cyc++;
            if (!m_busy) begin
                if (req_valid) begin
                    if (int'(req_idx) == m_f) m_triv = cyc;
                    else m_start(cyc, int'(req_idx));
                end
            end else if (cyc == td + 1) begin
                int nx; bit nv;
                nv = req_valid || m_pv;
                nx = req_valid ? int'(req_idx) : m_pend;
                m_pv = 0;
                if (nv && nx != m_f) m_start(cyc, nx);
                else m_busy = 0;
            end else if (req_valid) begin
                m_pv = 1; m_pend = int'(req_idx);
            end
            if (cyc == t1) begin if (m_up) m_v = tbl(m_tgt); else m_f = m_tgt; end
            if (cyc == t2) begin if (m_up) m_f = m_tgt; else m_v = tbl(m_tgt); end
        end
        e_v = m_v; e_f = m_f; e_busy = m_busy;
        e_done = rst_n && ((cyc == td) || (cyc == m_triv));
    end

    logic [3:0] prev_v;
    logic [2:0] prev_f;
    bit have_prev = 0;

    // per-clock comparison against the model, plus the one-step rule
    always @(negedge clk) begin
        if (rst_n) begin
            chk(volt_sel == 4'(e_v), "R3 model volt_sel", volt_sel, e_v);
            chk(clk_sel == 3'(e_f), "R4 model clk_sel", clk_sel, e_f);
            chk(busy == e_busy, "R2 model busy", busy, e_busy);
            chk(done == e_done, "R6 model done", done, e_done);
            if (have_prev)
                chk(!(volt_sel != prev_v && clk_sel != prev_f), "R11 both outputs moved", 1, 0);
            seen[clk_sel] = 1'b1;
            if (done) done_cnt++;
        end
        prev_v = volt_sel; prev_f = clk_sel; have_prev = rst_n;
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", wd, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int x);
        req_valid = 1'b1; req_idx = 3'(x);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        step(1);
    endtask

    initial begin
        seen = '0; done_cnt = 0;
        step(5);
        // R1 reset state
        chk(clk_sel == 3'd0, "R1 reset clk_sel", clk_sel, 0);
        chk(volt_sel == tbl(0), "R1 reset volt_sel", volt_sel, tbl(0));
        chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        step(2);

        // rising 0 -> 5 timing (R2, R4, R6)
        wr(5);
        chk(busy == 1'b1, "R2 busy after write", busy, 1);
        chk(volt_sel == tbl(0), "R4 volt not yet moved", volt_sel, tbl(0));
        step(1);
        chk(volt_sel == tbl(5), "R4 volt moves first", volt_sel, tbl(5));
        chk(clk_sel == 3'd0, "R4 clock held", clk_sel, 0);
        step(VS);
        chk(clk_sel == 3'd0, "R4 clock held through settle", clk_sel, 0);
        step(1);
        chk(clk_sel == 3'd5, "R4 clock moves after settle", clk_sel, 5);
        step(FS);
        chk(done == 1'b1, "R6 done after clock settle", done, 1);
        step(1);
        chk(!done && !busy, "R6 done one cycle, busy low", {done, busy}, 0);

        // same index write (R7)
        step(2);
        wr(5);
        chk(done == 1'b1 && busy == 1'b0, "R7 immediate done, no busy", {done, busy}, 2);
        step(1);
        chk(!done && clk_sel == 3'd5 && volt_sel == tbl(5), "R7 outputs unchanged", clk_sel, 5);

        // falling 5 -> 1 timing (R5)
        step(2);
        wr(1);
        chk(clk_sel == 3'd5, "R5 clock not yet moved", clk_sel, 5);
        step(1);
        chk(clk_sel == 3'd1, "R5 clock moves first", clk_sel, 1);
        chk(volt_sel == tbl(5), "R5 volt held", volt_sel, tbl(5));
        step(FS);
        chk(volt_sel == tbl(5), "R5 volt held through settle", volt_sel, tbl(5));
        step(1);
        chk(volt_sel == tbl(1), "R5 volt moves after settle", volt_sel, tbl(1));
        step(VS);
        chk(done == 1'b1, "R6 done after volt settle", done, 1);
        step(2);

        // parked requests, latest wins (R8)
        seen = '0;
        wr(3); step(2); wr(6); step(2); wr(4);
        wait_idle();
        chk(clk_sel == 3'd4, "R8 latest parked request applied", clk_sel, 4);
        chk(volt_sel == tbl(4), "R8 paired code", volt_sel, tbl(4));
        chk(seen[3] && !seen[6], "R8 first ran, stale dropped", seen, 8'h08);

        // write in done cycle beats parked one (R9)
        seen = '0;
        wr(7); step(3); wr(2);
        while (!done) @(negedge clk);
        wr(0);
        wait_idle();
        chk(clk_sel == 3'd0, "R9 done-cycle write wins", clk_sel, 0);
        chk(!seen[2], "R9 parked index never reached", seen[2], 0);

        // parked copy of target dropped (R10)
        wr(3); step(3); wr(3);
        done_cnt = 0;
        while (!done) @(negedge clk);
        step(1);
        chk(!busy && !done, "R10 no restart after duplicate", {busy, done}, 0);
        step(3);
        chk(done_cnt == 1, "R10 single done", done_cnt, 1);

        // sweep including end indices (R3)
        foreach (seen[k]) begin
            int t;
            t = (k * 5 + 7) % 8;
            wr(t);
            wait_idle();
            chk(clk_sel == 3'(t) && volt_sel == tbl(t), "R3 table pairing", volt_sel, tbl(t));
        end

        step(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule